// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital controller of a successive approximation converter. It accepts a start strobe that is active low and only counts while chip select is low, then runs a fixed sequence of binary-search steps against an external weighted DAC. Each step sets one trial bit and reads a single comparator decision one clock later, so one bit is decided per clock. The sequence runs from the most significant bit down to bit 0.

While idle the block keeps the input sampling network tracking and the comparator offset-zeroing switch closed. When a conversion starts it opens the zeroing switch and puts the sampling network into hold. The finished word is shaped into two's complement by inverting its top bit. It is loaded into an output register on the clock that ends the conversion, and the active-low busy flag rises on that same clock.

After each conversion a parameterised minimum acquire window runs before the next start. A request that arrives inside that window is remembered and starts the next conversion as soon as the window closes. A request that arrives while a conversion is running is dropped.

Top module: `sar_conv_seq`

## Requirements
- R1: A conversion starts only on a clock where `conv_n` is sampled low after having been sampled high on the previous clock, and `cs_n` is sampled low on that same clock. Holding `conv_n` low, or a falling edge while `cs_n` is high, starts nothing.
- R2: At the start the approximation register is cleared and only the MSB trial bit is set. During the first conversion cycle `dac_code` is 0x800.
- R3: A start request that arrives while a conversion runs has no effect. It does not restart or lengthen the conversion, and it is not queued for later.
- R4: Bits are decided MSB first, one per clock. In conversion cycle k (k = 0 to NBITS-1), `dac_code` holds the bits already decided above bit NBITS-1-k, then a 1 at bit NBITS-1-k, then zeros below. That bit is kept when `cmp_gt` is high at the clock edge that ends the cycle, and cleared otherwise.
- R5: While idle, `zero_en` is 1 and `hold` is 0. During a conversion, `hold` is 1 and `zero_en` is 0.
- R6: `data_out` changes only on the clock edge that ends a conversion. It keeps the previous result for the whole of the next conversion.
- R7: `busy_n` is low for exactly NBITS clock cycles per conversion. It rises on the same edge that loads `data_out`.
- R8: `data_out` is the decided code with its MSB inverted (two's complement). Decided code 0x7FF (input just below mid-scale) gives 0xFFF, 0xFFF gives 0x7FF, 0x000 gives 0x800, and 0x800 gives 0x000.
- R9: After `busy_n` rises it stays high for at least ACQ_CYC+1 cycles. A valid request made inside that window is held pending. The pending conversion then starts so that `busy_n` is high for exactly ACQ_CYC+1 cycles.
- R10: During reset, `busy_n` is 1, `hold` is 0, `zero_en` is 1, and `dac_code` and `data_out` are 0. The acquire window also runs from reset, so the first conversion starts no earlier than ACQ_CYC+1 cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal conversion clock, one bit decision per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low, qualifies the start strobe |
| conv_n | input | 1 | Start strobe, a conversion begins on its falling edge |
| cmp_gt | input | 1 | Comparator decision, 1 when the held input exceeds the DAC level |
| dac_code | output | NBITS | Trial code driven to the weighted DAC |
| hold | output | 1 | Sampling network in hold (1) or tracking (0) |
| zero_en | output | 1 | Comparator zeroing switch closed |
| busy_n | output | 1 | Low while a conversion is in progress |
| data_out | output | NBITS | Latched two's complement result |

## Verification
The bench builds the block with NBITS = 12, ACQ_CYC = 6 and the two's complement output shape, using an ideal quantiser that places the held input half an LSB above an integer code. This setting brings the full-scale corners within reach: mid-scale minus one, zero, and both extremes. It also exposes the full per-cycle trial sequence. The acquire window is long enough that a request can land inside it and be seen to wait, while a request made during a conversion can be seen to vanish. The high-time count of `busy_n` measures the window exactly.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   typedef enum logic {
      PH_ACQUIRE = 1'b0,
      PH_CONVERT = 1'b1
   } sar_phase_t;

   function automatic int cnt_width(input int max_val);
      return (max_val < 1) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/sar_req_gate.sv
module sar_req_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic conv_n,
   input  logic armed,
   input  logic in_conv,
   output logic start
);

   logic conv_q;
   logic pend_q;
   logic fall;

   assign fall  = conv_q & ~conv_n & ~cs_n;
   assign start = armed & (fall | pend_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_q <= 1'b1;
         pend_q <= 1'b0;
      end else begin
         conv_q <= conv_n;
         if (start) begin
            pend_q <= 1'b0;
         end else if (fall && !in_conv) begin
            pend_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/sar_acq_timer.sv
module sar_acq_timer #(
   parameter int ACQ_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic in_conv,
   output logic armed
);

   localparam int CW = sar_seq_pkg::cnt_width(ACQ_CYC);
   localparam logic [CW-1:0] CNT_MAX = CW'(ACQ_CYC);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (!in_conv && cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign armed = !in_conv && (cnt_q == CNT_MAX);

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
   parameter int NBITS = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cmp_gt,
   output logic [NBITS-1:0] trial,
   output logic [NBITS-1:0] word_nxt,
   output logic             in_conv,
   output logic             finish
);

   import sar_seq_pkg::*;

   localparam int IW = (NBITS < 2) ? 1 : $clog2(NBITS);
   localparam logic [IW-1:0] TOP_IDX = IW'(NBITS - 1);
   localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

   sar_phase_t      phase_q;
   logic [NBITS-1:0] sar_q;
   logic [IW-1:0]    idx_q;

   always_comb begin
      word_nxt = sar_q;
      word_nxt[idx_q] = cmp_gt;
      if (idx_q != '0) begin
         word_nxt[IW'(idx_q - 1'b1)] = 1'b1;
      end
   end

   assign in_conv = (phase_q == PH_CONVERT);
   assign finish  = in_conv && (idx_q == '0);
   assign trial   = sar_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_ACQUIRE;
         sar_q   <= '0;
         idx_q   <= '0;
      end else if (start && !in_conv) begin
         phase_q <= PH_CONVERT;
         sar_q   <= MSB_ONLY;
         idx_q   <= TOP_IDX;
      end else if (in_conv) begin
         sar_q <= word_nxt;
         if (finish) begin
            phase_q <= PH_ACQUIRE;
         end else begin
            idx_q <= IW'(idx_q - 1'b1);
         end
      end
   end

endmodule

// File: rtl/sar_out_latch.sv
module sar_out_latch #(
   parameter int NBITS    = 12,
   parameter bit OUT_TWOS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [NBITS-1:0] word,
   output logic [NBITS-1:0] q
);

   logic [NBITS-1:0] shaped;

   generate
      if (OUT_TWOS) begin : g_twos
         assign shaped = {~word[NBITS-1], word[NBITS-2:0]};
      end else begin : g_straight
         assign shaped = word;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= shaped;
      end
   end

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
   parameter int NBITS    = 12,
   parameter int ACQ_CYC  = 4,
   parameter bit OUT_TWOS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             conv_n,
   input  logic             cmp_gt,
   output logic [NBITS-1:0] dac_code,
   output logic             hold,
   output logic             zero_en,
   output logic             busy_n,
   output logic [NBITS-1:0] data_out
);

   generate
      if (NBITS < 2) begin : g_bad_width
         $error("sar_conv_seq: NBITS must be at least 2");
      end
      if (ACQ_CYC < 0) begin : g_bad_acq
         $error("sar_conv_seq: ACQ_CYC must not be negative");
      end
   endgenerate

   logic             start;
   logic             armed;
   logic             in_conv;
   logic             finish;
   logic [NBITS-1:0] word_nxt;

   sar_req_gate u_req_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (cs_n),
      .conv_n  (conv_n),
      .armed   (armed),
      .in_conv (in_conv),
      .start   (start)
   );

   sar_acq_timer #(.ACQ_CYC(ACQ_CYC)) u_acq_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (finish),
      .in_conv (in_conv),
      .armed   (armed)
   );

   sar_bit_engine #(.NBITS(NBITS)) u_bit_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cmp_gt   (cmp_gt),
      .trial    (dac_code),
      .word_nxt (word_nxt),
      .in_conv  (in_conv),
      .finish   (finish)
   );

   sar_out_latch #(.NBITS(NBITS), .OUT_TWOS(OUT_TWOS)) u_out_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (finish),
      .word  (word_nxt),
      .q     (data_out)
   );

   assign hold    = in_conv;
   assign zero_en = ~in_conv;
   assign busy_n  = ~in_conv;

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
   parameter int NBITS   = 12,
   parameter int ACQ_CYC = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy_n,
   input logic             hold,
   input logic             zero_en,
   input logic [NBITS-1:0] dac_code,
   input logic [NBITS-1:0] data_out
);

   localparam int LW = sar_seq_pkg::cnt_width(NBITS + 1);
   localparam int HW = sar_seq_pkg::cnt_width(ACQ_CYC + 1);
   localparam logic [HW-1:0] HI_CAP = HW'(ACQ_CYC + 1);

   logic [LW-1:0] lo_cnt;
   logic [HW-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cnt <= '0;
         hi_cnt <= '0;
      end else begin
         lo_cnt <= busy_n ? '0 : LW'(lo_cnt + 1'b1);
         if (!busy_n) begin
            hi_cnt <= '0;
         end else if (hi_cnt != HI_CAP) begin
            hi_cnt <= hi_cnt + 1'b1;
         end
      end
   end

   AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_n) |-> dac_code == {1'b1, {(NBITS-1){1'b0}}}); // R2

   AST_PHASE_SWITCHES: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_n |-> (hold && !zero_en)); // R5

   AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data_out) |-> $rose(busy_n)); // R6

   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_n) |-> lo_cnt == LW'(NBITS)); // R7

   AST_ACQ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_n) |-> hi_cnt > HW'(ACQ_CYC)); // R9

endmodule

bind sar_conv_seq sar_conv_seq_chk #(.NBITS(NBITS), .ACQ_CYC(ACQ_CYC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy_n   (busy_n),
   .hold     (hold),
   .zero_en  (zero_en),
   .dac_code (dac_code),
   .data_out (data_out)
);

// File: tb/sar_conv_seq_bench.sv
module sar_conv_seq_bench;

   localparam int NB  = 12;
   localparam int ACQ = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1;
   logic          conv_n = 1'b1;
   logic          cmp_gt;
   logic [NB-1:0] dac_code;
   logic          hold;
   logic          zero_en;
   logic          busy_n;
   logic [NB-1:0] data_out;

   logic [NB-1:0] ain = '0;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   // ideal quantiser: held input sits half an LSB above code ain
   assign cmp_gt = ({ain, 1'b1} > {dac_code, 1'b0});

   sar_conv_seq #(.NBITS(NB), .ACQ_CYC(ACQ), .OUT_TWOS(1'b1)) u_sar_conv_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .conv_n   (conv_n),
      .cmp_gt   (cmp_gt),
      .dac_code (dac_code),
      .hold     (hold),
      .zero_en  (zero_en),
      .busy_n   (busy_n),
      .data_out (data_out)
   );

   function automatic logic [NB-1:0] exp_word(input logic [NB-1:0] a);
      return {~a[NB-1], a[NB-2:0]};
   endfunction

   function automatic logic [NB-1:0] exp_trial(input logic [NB-1:0] a, input int k);
      logic [NB-1:0] upper_mask;
      upper_mask = ~((NB'(1) << (NB - k)) - 1'b1);
      if (k == 0) upper_mask = '0;
      return (a & upper_mask) | (NB'(1) << (NB - 1 - k));
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // one conversion; starts at a negedge with the block armed, ends at the
   // negedge after the result edge; inject drives a second strobe mid-way
   task automatic convert(input logic [NB-1:0] a, input bit inject);
      logic [NB-1:0] prev;
      prev = data_out;
      ain = a;
      cs_n = 1'b0;
      conv_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      conv_n = 1'b1;
      cs_n = 1'b1;
      for (int k = 0; k < NB; k++) begin
         if (k > 0) @(negedge clk);
         if (inject && k == 4) begin
            cs_n = 1'b0;
            conv_n = 1'b0;
         end
         if (inject && k == 6) begin
            conv_n = 1'b1;
            cs_n = 1'b1;
         end
         chk(busy_n == 1'b0, "R7 busy low in conversion", busy_n, 0);
         chk(dac_code == exp_trial(a, k), "R4 trial code", dac_code, exp_trial(a, k));
         chk(hold && !zero_en, "R5 convert switches", {hold, zero_en}, 2);
         chk(data_out == prev, "R6 result held", data_out, prev);
         if (k == 0) chk(dac_code == 12'h800, "R2 cleared with MSB trial", dac_code, 12'h800);
      end
      @(negedge clk);
      chk(busy_n == 1'b1, "R7 busy high after NBITS cycles", busy_n, 1);
      chk(data_out == exp_word(a), "R8 result word", data_out, exp_word(a));
      chk(!hold && zero_en, "R5 acquire switches", {hold, zero_en}, 1);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int hi;
      void'($urandom(32'h5A17));
      @(negedge clk);
      chk(busy_n == 1'b1, "R10 reset busy", busy_n, 1);
      chk(data_out == '0, "R10 reset data", data_out, 0);
      chk(dac_code == '0, "R10 reset dac", dac_code, 0);
      chk(!hold && zero_en, "R10 reset switches", {hold, zero_en}, 1);
      @(negedge clk);
      rst_n = 1'b1;

      // R10: request right after reset waits out the acquire window
      cs_n = 1'b0;
      conv_n = 1'b0;
      ain = 12'h123;
      hi = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         conv_n = 1'b1;
         if (!busy_n) break;
         hi++;
      end
      cs_n = 1'b1;
      chk(hi == ACQ, "R10 first start after window", hi, ACQ);
      idle(NB);
      chk(data_out == exp_word(12'h123), "R8 first result", data_out, exp_word(12'h123));
      idle(ACQ + 2);

      // R8 corners
      convert(12'h7FF, 1'b0);
      chk(data_out == 12'hFFF, "R8 just below zero", data_out, 12'hFFF);
      idle(ACQ + 2);
      convert(12'hFFF, 1'b0);
      chk(data_out == 12'h7FF, "R8 positive full scale", data_out, 12'h7FF);
      idle(ACQ + 2);
      convert(12'h000, 1'b0);
      chk(data_out == 12'h800, "R8 negative full scale", data_out, 12'h800);
      idle(ACQ + 2);
      convert(12'h800, 1'b0);
      chk(data_out == 12'h000, "R8 zero", data_out, 12'h000);
      idle(ACQ + 2);

      // R1: strobe with cs_n high, then conv_n held low while cs_n drops
      ain = 12'h555;
      conv_n = 1'b0;
      idle(3);
      cs_n = 1'b0;
      hi = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (busy_n) hi++;
      end
      chk(hi == 20, "R1 no start without qualified fall", hi, 20);
      chk(data_out == 12'h000, "R1 result untouched", data_out, 12'h000);
      conv_n = 1'b1;
      cs_n = 1'b1;
      idle(2);

      // R3: strobe mid-conversion is dropped, not queued
      convert(12'h3A5, 1'b1);
      hi = 0;
      for (int i = 0; i < ACQ + 8; i++) begin
         @(negedge clk);
         if (busy_n) hi++;
      end
      chk(hi == ACQ + 8, "R3 mid-conversion strobe ignored", hi, ACQ + 8);
      chk(data_out == exp_word(12'h3A5), "R3 result of running conversion", data_out, exp_word(12'h3A5));

      // R9: request right at the end is pending, starts after the window
      convert(12'h9C3, 1'b0);
      ain = 12'h1E7;
      cs_n = 1'b0;
      conv_n = 1'b0;
      hi = 1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         conv_n = 1'b1;
         cs_n = 1'b1;
         if (!busy_n) break;
         hi++;
      end
      chk(hi == ACQ + 1, "R9 pending request waits out window", hi, ACQ + 1);
      idle(NB);
      chk(busy_n == 1'b1, "R7 pending conversion done", busy_n, 1);
      chk(data_out == exp_word(12'h1E7), "R9 pending conversion result", data_out, exp_word(12'h1E7));
      idle(ACQ + 2);

      // random codes
      for (int n = 0; n < 40; n++) begin
         convert(NB'($urandom_range(4095, 0)), 1'b0);
         idle(ACQ + 1 + int'($urandom_range(3, 0)));
      end

      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         finish_run();
      end
   end

endmodule